// File: doc/BRIEF.md
# Per-Requester Hit/Miss Statistics Counter

This block keeps event counts for a cache. Each clock cycle it may accept one access event, flagged as a hit or a miss, tagged with a command type, a writeback flag, a full-system flag and a signed requester id. The value −1 (all ones) marks a device or writeback source. The block picks a requester bucket and bumps the matching counter. Hit and miss counts are kept apart, and there is one counter for each command type in each bucket. There are NUM_CPUS + 1 buckets. The last bucket, whose index is NUM_CPUS, collects device traffic.

Software can read any counter through an indexed read port, and the data comes back one cycle after the request. A miss budget can be loaded. Every counted miss lowers it by one, and when it runs out the block raises a one-cycle stop pulse that tells the environment to end the run.

The budget is tracked by a four-state machine:
- LIM_OFF: the budget is disabled.
- LIM_ARMED: the block is counting down.
- LIM_FIRE: the single stop cycle.
- LIM_SPENT: the budget is exhausted and no further pulse will come.

Its transitions are:
- load-nonzero: any state goes to LIM_ARMED.
- load-zero: any state goes to LIM_OFF.
- last-miss: LIM_ARMED goes to LIM_FIRE when a counted miss finds one remaining.
- fire-done: LIM_FIRE goes to LIM_SPENT unconditionally.

Top module: `hitmiss_stats`

## Requirements
- R1: A writeback event whose id is all ones (−1) is counted in bucket 0, whatever the full-system flag says.
- R2: A non-writeback event with the full-system flag set and id all ones is counted in bucket NUM_CPUS, the device bucket.
- R3: Any other non-writeback event is counted in bucket (id read as an unsigned ID_W-bit number) modulo NUM_CPUS. For example, all ones with the full-system flag clear and NUM_CPUS=4 gives bucket 3.
- R4: Each counted event adds exactly one to the single counter selected by hit/miss (ev_is_miss: 1 = miss), command index and bucket. All other counters keep their values.
- R5: A writeback event whose id is not all ones sets err_o, which stays set until reset. It changes no counter and does not consume the miss budget.
- R6: A read request sampled at a clock edge yields rd_valid=1 and the counter selected by rd_cmd, rd_bkt and rd_is_miss (1 = miss counter) after that edge. rd_valid is 0 in cycles with no request.
- R7: Loading a nonzero budget N arms the countdown. Each counted miss lowers it by one, and hits do not. The N-th counted miss makes stop_o high for exactly the one cycle after its edge. No further pulse comes until the budget is reloaded.
- R8: Loading a budget of zero disables the countdown, so stop_o stays low for any number of misses.
- R9: Counters are CNT_W bits wide and wrap to zero after the all-ones value.
- R10: After reset all counters read zero, and err_o, stop_o and rd_valid are 0 with the countdown disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An access event is present this cycle |
| ev_is_miss | input | 1 | 1 = miss, 0 = hit |
| ev_wb | input | 1 | Event is a writeback |
| ev_cmd | input | CMD_W | Command type index |
| ev_id | input | ID_W | Requester id, all ones = −1 |
| fs_mode | input | 1 | Full-system mode: all-ones id means a device |
| lim_load | input | 1 | Load the miss budget |
| lim_value | input | LIM_W | Budget value; zero disables |
| rd_req | input | 1 | Read request |
| rd_is_miss | input | 1 | Read the miss (1) or hit (0) counter |
| rd_cmd | input | CMD_W | Command index to read |
| rd_bkt | input | BKT_W | Bucket index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Read counter value |
| err_o | output | 1 | Sticky malformed-writeback flag |
| stop_o | output | 1 | One-cycle budget-exhausted pulse |

## Verification
An event sampled at edge k updates its counter at k, so a read requested at edge k+1 sees the new value. The read data is valid just after edge k+1. The stop pulse and the error flag are also due one edge after the event that causes them. The bench drives each event, read or budget load on a falling edge, and leaves it in place for one rising edge. It then samples stop_o, err_o, rd_valid and rd_data on the next falling edge, exactly one register stage after the stimulus.

// File: rtl/hitmiss_stats_pkg.sv
package hitmiss_stats_pkg;
    typedef enum logic [1:0] {
        LIM_OFF   = 2'd0,
        LIM_ARMED = 2'd1,
        LIM_FIRE  = 2'd2,
        LIM_SPENT = 2'd3
    } lim_state_t;
endpackage

// File: rtl/stat_bucket_sel.sv
module stat_bucket_sel #(
    parameter int NUM_CPUS = 4,
    parameter int ID_W     = 8,
    parameter int BKT_W    = 3
) (
    input  logic             ev_wb,
    input  logic             fs_mode,
    input  logic [ID_W-1:0]  ev_id,
    output logic [BKT_W-1:0] bkt,
    output logic             bad_wb
);
    logic             id_is_dev;
    logic [ID_W-1:0]  id_mod;

    always_comb begin
        id_is_dev = (ev_id == {ID_W{1'b1}});
        id_mod    = ev_id % ID_W'(NUM_CPUS);
        bad_wb    = ev_wb && !id_is_dev;
        if (ev_wb)
            bkt = '0;
        else if (fs_mode && id_is_dev)
            bkt = BKT_W'(NUM_CPUS);
        else
            bkt = BKT_W'(id_mod);
    end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
    parameter int NUM_CMDS = 4,
    parameter int NB       = 5,
    parameter int CNT_W    = 32,
    parameter int CMD_W    = 2,
    parameter int BKT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             inc_miss,
    input  logic [CMD_W-1:0] inc_cmd,
    input  logic [BKT_W-1:0] inc_bkt,
    input  logic             rd_req,
    input  logic             rd_is_miss,
    input  logic [CMD_W-1:0] rd_cmd,
    input  logic [BKT_W-1:0] rd_bkt,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data
);
    logic [CNT_W-1:0] hit_cnt  [NUM_CMDS][NB];
    logic [CNT_W-1:0] miss_cnt [NUM_CMDS][NB];

    for (genvar c = 0; c < NUM_CMDS; c++) begin : g_cmd
        for (genvar b = 0; b < NB; b++) begin : g_bkt
            logic sel;
            assign sel = inc_en && (int'(inc_cmd) == c) && (int'(inc_bkt) == b);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hit_cnt[c][b]  <= '0;
                    miss_cnt[c][b] <= '0;
                end else if (sel) begin
                    if (inc_miss)
                        miss_cnt[c][b] <= miss_cnt[c][b] + 1'b1;
                    else
                        hit_cnt[c][b]  <= hit_cnt[c][b] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                if (int'(rd_cmd) < NUM_CMDS && int'(rd_bkt) < NB)
                    rd_data <= rd_is_miss ? miss_cnt[rd_cmd][rd_bkt]
                                          : hit_cnt[rd_cmd][rd_bkt];
                else
                    rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/stat_miss_limit.sv
module stat_miss_limit
    import hitmiss_stats_pkg::*;
#(
    parameter int LIM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_load,
    input  logic [LIM_W-1:0] lim_value,
    input  logic             miss_tick,
    output logic             stop_o
);
    lim_state_t       state;
    logic [LIM_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LIM_OFF;
            remain <= '0;
        end else if (lim_load) begin
            remain <= lim_value;
            state  <= (lim_value == '0) ? LIM_OFF : LIM_ARMED;
        end else begin
            unique case (state)
                LIM_OFF:   state <= LIM_OFF;
                LIM_ARMED: begin
                    if (miss_tick) begin
                        if (remain == LIM_W'(1)) begin
                            remain <= '0;
                            state  <= LIM_FIRE;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                LIM_FIRE:  state <= LIM_SPENT;
                LIM_SPENT: state <= LIM_SPENT;
            endcase
        end
    end

    always_comb begin
        stop_o = (state == LIM_FIRE);
    end
endmodule

// File: rtl/hitmiss_stats.sv
module hitmiss_stats #(
    parameter int NUM_CPUS = 4,
    parameter int NUM_CMDS = 4,
    parameter int CNT_W    = 32,
    parameter int ID_W     = 8,
    parameter int LIM_W    = 32,
    localparam int NB      = NUM_CPUS + 1,
    localparam int CMD_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1,
    localparam int BKT_W   = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_is_miss,
    input  logic             ev_wb,
    input  logic [CMD_W-1:0] ev_cmd,
    input  logic [ID_W-1:0]  ev_id,
    input  logic             fs_mode,
    input  logic             lim_load,
    input  logic [LIM_W-1:0] lim_value,
    input  logic             rd_req,
    input  logic             rd_is_miss,
    input  logic [CMD_W-1:0] rd_cmd,
    input  logic [BKT_W-1:0] rd_bkt,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             err_o,
    output logic             stop_o
);
    logic [BKT_W-1:0] sel_bkt;
    logic             bad_wb;
    logic             counted;

    stat_bucket_sel #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W), .BKT_W(BKT_W)) u_sel (
        .ev_wb(ev_wb), .fs_mode(fs_mode), .ev_id(ev_id),
        .bkt(sel_bkt), .bad_wb(bad_wb)
    );

    assign counted = ev_valid && !bad_wb;

    stat_counter_bank #(.NUM_CMDS(NUM_CMDS), .NB(NB), .CNT_W(CNT_W),
                        .CMD_W(CMD_W), .BKT_W(BKT_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .inc_en(counted), .inc_miss(ev_is_miss), .inc_cmd(ev_cmd), .inc_bkt(sel_bkt),
        .rd_req(rd_req), .rd_is_miss(rd_is_miss), .rd_cmd(rd_cmd), .rd_bkt(rd_bkt),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    stat_miss_limit #(.LIM_W(LIM_W)) u_lim (
        .clk(clk), .rst_n(rst_n), .lim_load(lim_load), .lim_value(lim_value),
        .miss_tick(counted && ev_is_miss), .stop_o(stop_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (ev_valid && bad_wb)
            err_o <= 1'b1;
    end
endmodule

// File: rtl/hitmiss_stats_chk.sv
module hitmiss_stats_chk #(
    parameter int ID_W  = 8,
    parameter int LIM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_is_miss,
    input logic             ev_wb,
    input logic [ID_W-1:0]  ev_id,
    input logic             lim_load,
    input logic [LIM_W-1:0] lim_value,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             err_o,
    input logic             stop_o
);
    // R5
    bad_wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_wb && ev_id != {ID_W{1'b1}}) |=> err_o);
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R6
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R7
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);
    // R7
    stop_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> $past(ev_valid && ev_is_miss));
    // R8
    zero_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_load && lim_value == '0) |=> !stop_o);
endmodule

bind hitmiss_stats hitmiss_stats_chk #(.ID_W(ID_W), .LIM_W(LIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_miss(ev_is_miss),
    .ev_wb(ev_wb), .ev_id(ev_id), .lim_load(lim_load), .lim_value(lim_value),
    .rd_req(rd_req), .rd_valid(rd_valid), .err_o(err_o), .stop_o(stop_o)
);

// File: tb/sim_hitmiss_stats.sv
module sim_hitmiss_stats;
    localparam int CW = 8;
    localparam int NV = 10;
    // entry: {wb, miss, fs, cmd[2], id[8], expected bucket[3]}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 8'd2,   3'd2},   // R3
        {1'b0, 1'b1, 1'b0, 2'd1, 8'd6,   3'd2},   // R3 wrap by modulo
        {1'b0, 1'b0, 1'b1, 2'd2, 8'hFF,  3'd4},   // R2 device
        {1'b0, 1'b1, 1'b0, 2'd3, 8'hFF,  3'd3},   // R3 all ones, fs off
        {1'b1, 1'b0, 1'b0, 2'd1, 8'hFF,  3'd0},   // R1
        {1'b1, 1'b1, 1'b1, 2'd0, 8'hFF,  3'd0},   // R1 fs on
        {1'b0, 1'b1, 1'b1, 2'd0, 8'd5,   3'd1},   // R3
        {1'b0, 1'b0, 1'b0, 2'd3, 8'd3,   3'd3},   // R3
        {1'b0, 1'b1, 1'b1, 2'd2, 8'hFF,  3'd4},   // R2
        {1'b0, 1'b0, 1'b0, 2'd0, 8'd4,   3'd0}    // R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 0, ev_is_miss = 0, ev_wb = 0, fs_mode = 0;
    logic [1:0] ev_cmd = '0;
    logic [7:0] ev_id = '0;
    logic lim_load = 0;
    logic [31:0] lim_value = '0;
    logic rd_req = 0, rd_is_miss = 0;
    logic [1:0] rd_cmd = '0;
    logic [2:0] rd_bkt = '0;
    logic rd_valid, err_o, stop_o;
    logic [CW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int model [2][4][5];

    always #2 clk = ~clk;

    hitmiss_stats #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_miss(ev_is_miss),
        .ev_wb(ev_wb), .ev_cmd(ev_cmd), .ev_id(ev_id), .fs_mode(fs_mode),
        .lim_load(lim_load), .lim_value(lim_value), .rd_req(rd_req),
        .rd_is_miss(rd_is_miss), .rd_cmd(rd_cmd), .rd_bkt(rd_bkt),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_o(err_o), .stop_o(stop_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ev(input bit wb, input bit miss, input bit fs,
                         input logic [1:0] cmd, input logic [7:0] id, output bit stp);
        @(negedge clk);
        ev_valid = 1; ev_wb = wb; ev_is_miss = miss; fs_mode = fs; ev_cmd = cmd; ev_id = id;
        @(negedge clk);
        ev_valid = 0;
        stp = stop_o;
    endtask

    task automatic counted_ev(input bit miss, input logic [1:0] cmd, input logic [7:0] id,
                              input int bkt, output bit stp);
        do_ev(1'b0, miss, 1'b0, cmd, id, stp);
        model[miss][cmd][bkt]++;
    endtask

    task automatic do_read(input bit miss, input logic [1:0] cmd, input logic [2:0] bkt,
                           output int data, output bit vld);
        @(negedge clk);
        rd_req = 1; rd_is_miss = miss; rd_cmd = cmd; rd_bkt = bkt;
        @(negedge clk);
        rd_req = 0;
        data = int'(rd_data);
        vld = rd_valid;
    endtask

    task automatic do_load(input logic [31:0] v);
        @(negedge clk);
        lim_load = 1; lim_value = v;
        @(negedge clk);
        lim_load = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d;
        bit v, s;
        foreach (model[a, b, c]) model[a][b][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 err", int'(err_o), 0);
        chk("R10 stop", int'(stop_o), 0);
        chk("R10 rd_valid", int'(rd_valid), 0);
        do_read(1'b1, 2'd2, 3'd4, d, v);
        chk("R10 counter", d, 0);
        chk("R6 valid", int'(v), 1);
        @(negedge clk);
        chk("R6 idle valid", int'(rd_valid), 0);

        // R1 R2 R3 R4 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] e;
            e = VEC[i];
            do_ev(e[15], e[14], e[13], e[12:11], e[10:3], s);
            model[e[14]][e[12:11]][e[2:0]]++;
            do_read(e[14], e[12:11], e[2:0], d, v);
            chk("R4 bucket counter", d, model[e[14]][e[12:11]][e[2:0]]);
            do_read(!e[14], e[12:11], e[2:0], d, v);
            chk("R4 other type untouched", d, model[!e[14]][e[12:11]][e[2:0]]);
        end
        chk("R5 no error yet", int'(err_o), 0);

        // R5 malformed writeback
        do_ev(1'b1, 1'b0, 1'b0, 2'd2, 8'd3, s);
        chk("R5 err set", int'(err_o), 1);
        do_read(1'b0, 2'd2, 3'd0, d, v);
        chk("R5 bucket0 unchanged", d, model[0][2][0]);
        do_read(1'b0, 2'd2, 3'd3, d, v);
        chk("R5 bucket3 unchanged", d, model[0][2][3]);
        counted_ev(1'b0, 2'd0, 8'd1, 1, s);
        chk("R5 err sticky", int'(err_o), 1);

        // R7 budget of 3, hits do not consume
        do_load(32'd3);
        counted_ev(1'b1, 2'd3, 8'd2, 2, s); chk("R7 miss1 no stop", int'(s), 0);
        counted_ev(1'b0, 2'd3, 8'd2, 2, s); chk("R7 hit no stop", int'(s), 0);
        counted_ev(1'b1, 2'd3, 8'd2, 2, s); chk("R7 miss2 no stop", int'(s), 0);
        counted_ev(1'b1, 2'd3, 8'd2, 2, s); chk("R7 miss3 stop", int'(s), 1);
        @(negedge clk);
        chk("R7 pulse one cycle", int'(stop_o), 0);
        counted_ev(1'b1, 2'd3, 8'd2, 2, s); chk("R7 spent no stop", int'(s), 0);

        // R5 R7 bad writeback miss does not consume budget
        do_load(32'd1);
        do_ev(1'b1, 1'b1, 1'b0, 2'd3, 8'd0, s);
        chk("R5 bad wb no decrement", int'(s), 0);
        counted_ev(1'b1, 2'd3, 8'd2, 2, s); chk("R7 budget1 stop", int'(s), 1);

        // R8 zero budget
        do_load(32'd0);
        begin
            bit any;
            any = 0;
            for (int k = 0; k < 5; k++) begin
                counted_ev(1'b1, 2'd3, 8'd2, 2, s);
                any |= s;
            end
            chk("R8 never stops", int'(any), 0);
        end

        // R9 wrap
        for (int k = 0; k < 260; k++) counted_ev(1'b0, 2'd1, 8'd1, 1, s);
        do_read(1'b0, 2'd1, 3'd1, d, v);
        chk("R9 wrapped value", d, model[0][1][1] % 256);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule